// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a general-purpose I/O peripheral with up to 32 pins, reached through a plain synchronous 32-bit register port. Software sets each pin's direction, drives the output levels, reads the live pin levels back, and programs an interrupt source for every pin. The host sees one combined interrupt line.

Every input pin passes through a two-flop synchronizer. The synchronized level then feeds a per-pin detector. A mode bit sets each detector to level or single-edge sensing, and a polarity bit picks the active sense. A detected event sets a sticky status bit. A separate enable mask decides which status bits count as pending, and the interrupt line is the OR of the pending bits. Writing ones to the clear register drops status bits. A level source that is still active sets its bit again on the same cycle, so software must remove the cause before a clear takes effect.

Register word offsets (the word index is address bits [4:2]):
- 0x00: value
- 0x04: direction
- 0x08: enable
- 0x0C: status
- 0x10: pending
- 0x14: clear
- 0x18: mode
- 0x1C: polarity

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held and just after it, the following hold: direction is all ones (all pins are inputs), the output register is 0, enable is 0, mode is 0, polarity is 0, read data is 0 and `irq_o` is 0.
- R2: Direction (0x04) bit i = 1 makes pin i an input, and 0 makes it an output. `pin_oe_o[i]` is the inverse of direction bit i, effective the cycle after the write.
- R3: A write to value (0x00) sets `pin_out_o` the cycle after the write. A read of value returns, for input pins, the synchronized pin level and, for output pins, the driven level.
- R4: Each pin input passes two synchronizer flops. In level mode (mode bit 0), status bit i is set on every cycle that the synchronized level equals polarity bit i (1 = active high, 0 = active low).
- R5: In edge mode (mode bit at 0x18 = 1), polarity 0 latches a rising edge and polarity 1 latches a falling edge of the synchronized level. Edges of the other direction are ignored. A latched status bit stays set until it is cleared.
- R6: Writing 1 to bit i of clear (0x14) clears status bit i on the next cycle. Writing 0 leaves that bit unchanged. A set condition present in the same cycle wins over the clear.
- R7: Pending (0x10) is status AND enable (0x08). Status (0x0C) latches events whether or not the pin is enabled.
- R8: `irq_o` is 1 exactly when any pending bit is 1. Setting an enable bit on an already latched status raises `irq_o` the cycle after the write.
- R9: Register bits at and above PINS read as 0, and writes to those bits are ignored.
- R10: Read data is registered: it is valid the cycle after `bus_rd_i` and is 0 in any cycle that follows no read. The clear offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 5 | Byte address; bits [4:2] select the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | PINS | Pin levels from the pads |
| pin_out_o | output | PINS | Levels to drive on the pins |
| pin_oe_o | output | PINS | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
A wrong synchronizer or edge-history flop shows up as a status bit that appears one cycle early or late, or on the wrong edge direction. This becomes visible on `irq_o` for enabled pins in that same cycle, and in the next status read. A clear that loses to nothing, or a polarity that is decoded differently per mode, leaves a status or pending bit that differs from the reference model on the first read after the event. Register corruption is caught on `pin_out_o`, `pin_oe_o` or the registered read data one cycle after the offending write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 5;

  // Register word index, taken from address bits [4:2]
  typedef enum logic [2:0] {
    REG_VALUE = 3'd0,
    REG_DIR   = 3'd1,
    REG_IEN   = 3'd2,
    REG_STAT  = 3'd3,
    REG_PEND  = 3'd4,
    REG_CLR   = 3'd5,
    REG_MODE  = 3'd6,
    REG_POL   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // cycles since reset, saturating, used only to qualify the check below
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R4
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] level_i,
  input  logic [PINS-1:0] mode_i,
  input  logic [PINS-1:0] pol_i,
  input  logic [PINS-1:0] ien_i,
  input  logic [PINS-1:0] clr_i,
  output logic [PINS-1:0] status_o,
  output logic [PINS-1:0] pending_o,
  output logic            irq_o
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] status_q;
  logic [PINS-1:0] status_d;
  logic [PINS-1:0] set_w;

  for (genvar g = 0; g < PINS; g++) begin : g_det
    logic rise_w;
    logic fall_w;
    assign rise_w   = level_i[g] & ~prev_q[g];
    assign fall_w   = ~level_i[g] & prev_q[g];
    assign set_w[g] = mode_i[g] ? (pol_i[g] ? fall_w : rise_w)
                                : (level_i[g] == pol_i[g]);
  end

  always_comb begin
    status_d = (status_q & ~clr_i) | set_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level_i;
      status_q <= status_d;
    end
  end

  assign status_o  = status_q;
  assign pending_o = status_q & ien_i;
  assign irq_o     = |pending_o;

  // R5
  new_bit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q) & ~$past(set_w)) == '0));

  // R6
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & $past(clr_i & ~set_w)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic [PINS-1:0]   pin_in_i,
  output logic [PINS-1:0]   pin_out_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              irq_o
);
  reg_idx_e        idx_w;
  logic [PINS-1:0] wr_data_w;
  logic [PINS-1:0] sync_w;
  logic [PINS-1:0] status_w;
  logic [PINS-1:0] pending_w;
  logic [PINS-1:0] clr_w;

  logic [PINS-1:0] out_q, dir_q, ien_q, mode_q, pol_q;
  logic            out_en, dir_en, ien_en, mode_en, pol_en;
  logic [PINS-1:0] rd_sel;
  logic [BUS_W-1:0] rdata_d, rdata_q;

  assign idx_w     = reg_idx_e'(bus_addr_i[4:2]);
  assign wr_data_w = bus_wdata_i[PINS-1:0];

  gpio_sync #(.W(PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (sync_w)
  );

  gpio_irq_unit #(.PINS(PINS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (sync_w),
    .mode_i   (mode_q),
    .pol_i    (pol_q),
    .ien_i    (ien_q),
    .clr_i    (clr_w),
    .status_o (status_w),
    .pending_o(pending_w),
    .irq_o    (irq_o)
  );

  // write decode: clock enables per register
  always_comb begin
    out_en  = bus_wr_i && (idx_w == REG_VALUE);
    dir_en  = bus_wr_i && (idx_w == REG_DIR);
    ien_en  = bus_wr_i && (idx_w == REG_IEN);
    mode_en = bus_wr_i && (idx_w == REG_MODE);
    pol_en  = bus_wr_i && (idx_w == REG_POL);
    clr_w   = (bus_wr_i && (idx_w == REG_CLR)) ? wr_data_w : '0;
  end

  // read mux, zero-extended to the bus width
  always_comb begin
    rd_sel = '0;
    if (bus_rd_i) begin
      unique case (idx_w)
        REG_VALUE: rd_sel = (dir_q & sync_w) | (~dir_q & out_q);
        REG_DIR:   rd_sel = dir_q;
        REG_IEN:   rd_sel = ien_q;
        REG_STAT:  rd_sel = status_w;
        REG_PEND:  rd_sel = pending_w;
        REG_CLR:   rd_sel = '0;
        REG_MODE:  rd_sel = mode_q;
        REG_POL:   rd_sel = pol_q;
        default:   rd_sel = '0;
      endcase
    end
    rdata_d = '0;
    rdata_d[PINS-1:0] = rd_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '1;
      ien_q   <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (out_en)  out_q  <= wr_data_w;
      if (dir_en)  dir_q  <= wr_data_w;
      if (ien_en)  ien_q  <= wr_data_w;
      if (mode_en) mode_q <= wr_data_w;
      if (pol_en)  pol_q  <= wr_data_w;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign pin_out_o   = out_q;
  assign pin_oe_o    = ~dir_q;

  // R10
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_rd_i) |-> (bus_rdata_o == '0));

  // R8
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int unsigned PINS = 12;
  localparam logic [31:0] MASK = 32'((64'd1 << PINS) - 64'd1);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [4:0]      addr;
  logic            wr;
  logic [31:0]     wdata;
  logic            rd;
  logic [31:0]     rdata;
  logic [PINS-1:0] pin_in;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] pin_oe;
  logic            irq;

  int tests  = 0;
  int failed = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.PINS(PINS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dir, m_out, m_ien, m_mode, m_pol, m_stat, m_rdata;
  logic [31:0] hist[$];
  int          m_last_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = MASK; m_out = 0; m_ien = 0; m_mode = 0; m_pol = 0;
      m_stat = 0; m_rdata = 0; m_last_idx = 5;
      hist = {32'd0, 32'd0, 32'd0};
    end else begin
      logic [31:0] lvl, old, setv, clrv;
      int ix;
      lvl = hist[1];
      old = hist[2];
      setv = 0;
      for (int i = 0; i < PINS; i++) begin
        if (m_mode[i])
          setv[i] = m_pol[i] ? (old[i] && !lvl[i]) : (!old[i] && lvl[i]);
        else
          setv[i] = (lvl[i] == m_pol[i]);
      end
      ix = int'(addr[4:2]);
      m_rdata = 0;
      if (rd) begin
        m_last_idx = ix;
        case (ix)
          0: m_rdata = (m_dir & lvl) | (~m_dir & m_out & MASK);
          1: m_rdata = m_dir;
          2: m_rdata = m_ien;
          3: m_rdata = m_stat;
          4: m_rdata = m_stat & m_ien;
          6: m_rdata = m_mode;
          7: m_rdata = m_pol;
          default: m_rdata = 0;
        endcase
      end
      clrv = (wr && ix == 5) ? (wdata & MASK) : 0;
      m_stat = (m_stat & ~clrv) | setv;
      if (wr) begin
        case (ix)
          0: m_out  = wdata & MASK;
          1: m_dir  = wdata & MASK;
          2: m_ien  = wdata & MASK;
          6: m_mode = wdata & MASK;
          7: m_pol  = wdata & MASK;
          default: ;
        endcase
      end
      hist.push_front(32'(pin_in));
      void'(hist.pop_back());
    end
  end

  function automatic string rd_tag(int ix);
    case (ix)
      0: return "R3";
      1: return "R2";
      2: return "R7";
      3: return "R5";
      4: return "R7";
      6: return "R5";
      7: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(32'(pin_out), m_out, "R3 pin_out");
      check(32'(pin_oe), ~m_dir & MASK, "R2 pin_oe");
      check({31'd0, irq}, {31'd0, |(m_stat & m_ien)}, "R8 irq");
      check(rdata, m_rdata, rd_tag(m_last_idx));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      failed++;
      tests++;
      $display("FAIL watchdog expired actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_rd(a, d);
    check(d, exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; addr = 0; wr = 0; wdata = 0; rd = 0; pin_in = '0;
    idle(3);
    // R1 reset state at the ports
    check({31'd0, irq}, 32'd0, "R1 irq in reset");
    check(32'(pin_oe), 32'd0, "R1 oe in reset");
    check(32'(pin_out), 32'd0, "R1 out in reset");
    check(rdata, 32'd0, "R1 rdata in reset");
    rst_n = 1'b1;
    idle(2);
    expect_rd(5'h04, 32'h0000_0FFF, "R1 dir reset, R9 upper zero");
    expect_rd(5'h08, 32'h0, "R1 enable reset");
    expect_rd(5'h18, 32'h0, "R1 mode reset");
    // pins low, level mode, active-low polarity: all status bits set
    expect_rd(5'h0C, 32'h0000_0FFF, "R4 level low after reset");

    // direction and value
    bus_wr(5'h04, 32'h0000_0FF0);
    check(32'(pin_oe), 32'h00F, "R2 oe after dir write");
    bus_wr(5'h00, 32'h0000_0A5A);
    check(32'(pin_out), 32'hA5A, "R3 pin_out after write");
    pin_in = 12'h3C0;
    idle(4);
    expect_rd(5'h00, 32'h0000_03CA, "R3 value read mixes in/out");
    bus_wr(5'h00, 32'hFFFF_FFFF);
    check(32'(pin_out), 32'hFFF, "R9 upper write bits ignored");
    expect_rd(5'h00, 32'h0000_03CF, "R3 value read after write");

    // interrupt configuration
    bus_wr(5'h18, 32'h0000_0F00);
    bus_wr(5'h1C, 32'hFFFF_F330);
    expect_rd(5'h1C, 32'h0000_0330, "R9 polarity upper bits read zero");
    bus_wr(5'h14, 32'h0000_0FFF);
    bus_wr(5'h08, 32'h0000_0FF0);
    idle(2);
    expect_rd(5'h0C, 32'h0000_000F, "R6 active level survives clear");
    check({31'd0, irq}, 32'd0, "R8 no pending");
    expect_rd(5'h14, 32'h0, "R10 clear offset reads zero");

    // level high on pin 4
    pin_in = 12'h3D0;
    idle(4);
    check({31'd0, irq}, 32'd1, "R8 irq on level high");
    expect_rd(5'h10, 32'h0000_0010, "R7 pending level pin");
    bus_wr(5'h14, 32'h0000_0010);
    idle(1);
    expect_rd(5'h0C, 32'h0000_001F, "R6 clear loses to active level");
    pin_in = 12'h3C0;
    idle(4);
    bus_wr(5'h14, 32'h0000_0010);
    idle(1);
    expect_rd(5'h0C, 32'h0000_000F, "R6 clear after source inactive");
    check({31'd0, irq}, 32'd0, "R8 irq drops");

    // active-low level on pin 6
    pin_in = 12'h380;
    idle(4);
    expect_rd(5'h0C, 32'h0000_004F, "R4 active-low level");
    expect_rd(5'h10, 32'h0000_0040, "R7 pending low level");
    pin_in = 12'h3C0;
    idle(4);
    bus_wr(5'h14, 32'h0000_0040);
    idle(1);

    // falling edge on pin 8
    pin_in = 12'h2C0;
    idle(4);
    expect_rd(5'h0C, 32'h0000_010F, "R5 falling edge latched");
    pin_in = 12'h3C0;
    idle(4);
    expect_rd(5'h0C, 32'h0000_010F, "R5 edge sticky, rise ignored");
    bus_wr(5'h14, 32'h0000_0100);
    idle(1);
    expect_rd(5'h0C, 32'h0000_000F, "R6 edge cleared");

    // rising edge on pin 10
    pin_in = 12'h7C0;
    idle(4);
    expect_rd(5'h0C, 32'h0000_040F, "R5 rising edge latched");
    pin_in = 12'h3C0;
    idle(4);
    bus_wr(5'h14, 32'h0000_0000);
    idle(1);
    expect_rd(5'h0C, 32'h0000_040F, "R6 zero clear no effect");
    bus_wr(5'h14, 32'h0000_0400);
    idle(1);
    expect_rd(5'h0C, 32'h0000_000F, "R6 rising edge cleared");

    // enable gating
    bus_wr(5'h08, 32'h0);
    pin_in = 12'hBC0;
    idle(4);
    expect_rd(5'h0C, 32'h0000_080F, "R7 status latches while disabled");
    expect_rd(5'h10, 32'h0, "R7 pending masked");
    check({31'd0, irq}, 32'd0, "R8 masked irq");
    bus_wr(5'h08, 32'h0000_0800);
    check({31'd0, irq}, 32'd1, "R8 irq on late enable");
    expect_rd(5'h10, 32'h0000_0800, "R7 pending after enable");
    idle(3);
    check(rdata, 32'd0, "R10 rdata zero without read");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule